// File: doc/BRIEF.md
# Multi-rail power-good delay sequencer

This block brings up four supply rails in order and holds a system reset until all of them are good. Each rail has an external comparator, outside this block, that supplies a synchronized "rail above threshold" level. A rail's active-low good output goes low only after that level has stayed high for a delay chosen by a 2-bit code. When all four good outputs are low, a fifth delay stage starts. Its own 2-bit code sets how long it waits before it releases the active-low system reset.

All delays are counted in ticks of a prescaler that divides the system clock. A 1 ms tick gives delays of 100 ms, 500 ms, 1 s or 5 s. A manual-reset input is synchronized and debounced. While it is held, it forces every good output inactive and holds the system reset asserted. When it is released, the whole sequence runs again from the start.

Top module: `pwrseq_top`

## Requirements
- R1: After the synchronous reset, and while every rail input is low, all good outputs read 1 (inactive) and sys_rst_n reads 0.
- R2: A rail's good output goes to 0 only after its rail input has been high continuously for its programmed delay. The code for rail i sits in rail_dly_code[2i+1:2i]: 00 = 100 ticks, 01 = 500, 10 = 1000, 11 = 5000. Code 00 is the intended power-up setting.
- R3: When a rail input goes low, that rail's good output returns to 1 within two clock cycles. A low input during a delay count discards the count, and qualification restarts from zero when the input rises again.
- R4: sys_rst_n is 0 whenever any good output has been 1 in the previous cycle.
- R5: sys_rst_n rises only after all four good outputs have been 0 for the reset delay. That delay is selected by rst_dly_code with the same encoding as R2 (00 = 100, 01 = 500, 10 = 1000, 11 = 5000 ticks).
- R6: A manual-reset level held for at least MR_STABLE_CYCLES clock cycles, after a two-flop synchronizer, drives all good outputs to 1 and sys_rst_n to 0 until it is removed. A shorter pulse has no effect.
- R7: When manual reset is released and all rails are still valid, each good output and then sys_rst_n are released again after their full programmed delays.
- R8: A delay code that changes while its stage is counting takes effect only at the next start of that stage's count.
- R9: The channels are independent. A rail that stays low keeps its own good output at 1 and sys_rst_n at 0, and it does not change the timing of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok | input | 4 | Synchronized rail-above-threshold level, one bit per rail |
| mr_in | input | 1 | Asynchronous manual-reset request, active high |
| rail_dly_code | input | 8 | 2-bit delay code per rail; rail i uses bits [2i+1:2i] |
| rst_dly_code | input | 2 | 2-bit delay code for the reset release stage |
| good_n | output | 4 | Active-low power-good output per rail |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench applies rail patterns with mixed codes on each channel. It measures, to within one tick, the cycle at which each good output falls and at which the reset releases. A stage that used the wrong code, or that started counting from the wrong event, falls outside these windows. A rail input that glitches low partway through a count checks that the count restarts from zero; a design that only paused its counter would assert good too early. Two directed cases cover the edges of the manual-reset debounce and a code rewritten during a count. If the debounce is missing, a short pulse collapses the chain. If the code is not latched at the start of a count, the changed delay takes effect early.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int unsigned N_RAILS = 4;

    localparam int unsigned DLY_T0 = 100;
    localparam int unsigned DLY_T1 = 500;
    localparam int unsigned DLY_T2 = 1000;
    localparam int unsigned DLY_T3 = 5000;
    localparam int unsigned DLY_CNT_W = $clog2(DLY_T3 + 1);

    typedef logic [1:0] dly_code_t;
    typedef logic [DLY_CNT_W-1:0] dly_cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } stage_st_t;

    localparam dly_code_t DLY_CODE_DEFAULT = 2'b00;

    // Number of ticks selected by a 2-bit delay code.
    function automatic dly_cnt_t dly_ticks(input dly_code_t code);
        case (code)
            2'b00:   return dly_cnt_t'(DLY_T0);
            2'b01:   return dly_cnt_t'(DLY_T1);
            2'b10:   return dly_cnt_t'(DLY_T2);
            default: return dly_cnt_t'(DLY_T3);
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_tick_gen.sv
module pwrseq_tick_gen #(
    parameter int unsigned TICK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    generate
        if (TICK_CYCLES <= 1) begin : g_every
            always_ff @(posedge clk) begin
                if (rst) tick <= 1'b0;
                else     tick <= 1'b1;
            end
        end else begin : g_div
            localparam int unsigned W = $clog2(TICK_CYCLES);
            logic [W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                    tick  <= 1'b0;
                end else if (div_q == W'(TICK_CYCLES - 1)) begin
                    div_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    div_q <= div_q + 1'b1;
                    tick  <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pwrseq_mr_filter.sv
module pwrseq_mr_filter #(
    parameter int unsigned STABLE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_raw,
    output logic mr_act
);

    localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] stab_q;

    // Two-flop synchronizer, then a level must differ from the accepted
    // state for STABLE_CYCLES consecutive cycles before it is taken.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            stab_q <= '0;
            mr_act <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], mr_raw};
            if (sync_q[1] != mr_act) begin
                if (stab_q == CW'(STABLE_CYCLES - 1)) begin
                    mr_act <= sync_q[1];
                    stab_q <= '0;
                end else begin
                    stab_q <= stab_q + 1'b1;
                end
            end else begin
                stab_q <= '0;
            end
        end
    end

endmodule

// File: rtl/pwrseq_delay_stage.sv
module pwrseq_delay_stage
    import pwrseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      qual,
    input  dly_code_t code,
    output logic      done
);

    stage_st_t st_q;
    dly_cnt_t  cnt_q;
    dly_cnt_t  lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            lim_q <= dly_ticks(DLY_CODE_DEFAULT);
        end else begin
            case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (qual) begin
                        // the code is latched only here, at the start of a count
                        lim_q <= dly_ticks(code);
                        st_q  <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (!qual) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else if (tick) begin
                        if (cnt_q == lim_q - 1'b1) st_q <= ST_DONE;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!qual) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done = (st_q == ST_DONE);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int unsigned TICK_CYCLES      = 100000,
    parameter int unsigned MR_STABLE_CYCLES = 500
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_RAILS-1:0]     rail_ok,
    input  logic                   mr_in,
    input  logic [2*N_RAILS-1:0]   rail_dly_code,
    input  logic [1:0]             rst_dly_code,
    output logic [N_RAILS-1:0]     good_n,
    output logic                   sys_rst_n
);

    logic               tick;
    logic               mr_act;
    logic [N_RAILS-1:0] rail_done;
    logic               rst_done;

    pwrseq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pwrseq_mr_filter #(.STABLE_CYCLES(MR_STABLE_CYCLES)) u_mr (
        .clk    (clk),
        .rst    (rst),
        .mr_raw (mr_in),
        .mr_act (mr_act)
    );

    generate
        for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
            pwrseq_delay_stage u_stage (
                .clk  (clk),
                .rst  (rst),
                .tick (tick),
                .qual (rail_ok[g] & ~mr_act),
                .code (rail_dly_code[2*g +: 2]),
                .done (rail_done[g])
            );
            assign good_n[g] = ~rail_done[g];
        end
    endgenerate

    pwrseq_delay_stage u_rst_stage (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .qual ((&rail_done) & ~mr_act),
        .code (rst_dly_code),
        .done (rst_done)
    );

    assign sys_rst_n = rst_done;

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker
    import pwrseq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [N_RAILS-1:0] rail_ok,
    input logic               mr_act,
    input logic [N_RAILS-1:0] good_n,
    input logic               sys_rst_n
);

    p_rst_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (|good_n) |=> !sys_rst_n);

    p_mr_good_r6: assert property (@(posedge clk) disable iff (rst)
        mr_act |=> (&good_n));

    p_mr_rst_r6: assert property (@(posedge clk) disable iff (rst)
        mr_act |=> !sys_rst_n);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> ($past(good_n) == '0 && !$past(mr_act)));

    generate
        for (genvar g = 0; g < N_RAILS; g++) begin : g_chk
            p_drop_r3: assert property (@(posedge clk) disable iff (rst)
                !rail_ok[g] |=> good_n[g]);

            p_good_needs_rail_r2: assert property (@(posedge clk) disable iff (rst)
                $fell(good_n[g]) |-> ($past(rail_ok[g]) && !$past(mr_act)));
        end
    endgenerate

endmodule

bind pwrseq_top pwrseq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rail_ok   (rail_ok),
    .mr_act    (mr_act),
    .good_n    (good_n),
    .sys_rst_n (sys_rst_n)
);

// File: tb/pwrseq_top_tb.sv
module pwrseq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TC  = 4;
    localparam int MRS = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] rail_ok;
    logic       mr_in;
    logic [7:0] rail_dly_code;
    logic [1:0] rst_dly_code;
    logic [3:0] good_n;
    logic       sys_rst_n;

    int n_checks = 0;
    int n_fail   = 0;
    int fall_t [4];
    int rise_t;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrseq_top #(.TICK_CYCLES(TC), .MR_STABLE_CYCLES(MRS)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .rail_ok       (rail_ok),
        .mr_in         (mr_in),
        .rail_dly_code (rail_dly_code),
        .rst_dly_code  (rst_dly_code),
        .good_n        (good_n),
        .sys_rst_n     (sys_rst_n)
    );

    function automatic int exp_ticks(input logic [1:0] c);
        case (c)
            2'b00:   return 100;
            2'b01:   return 500;
            2'b10:   return 1000;
            default: return 5000;
        endcase
    endfunction

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input string what, input int act,
                           input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=[%0d..%0d]", req, what, act, lo, hi);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int maxc);
        for (int i = 0; i < 4; i++) fall_t[i] = -1;
        rise_t = -1;
        for (int c = 1; c <= maxc; c++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++)
                if (good_n[i] == 1'b0 && fall_t[i] < 0) fall_t[i] = c;
            if (sys_rst_n && rise_t < 0) rise_t = c;
        end
    endtask

    // Measure a full sequence from the current negedge and check it against
    // the codes in force; extra widens the upper bound (manual-reset release).
    task automatic run_and_check(input string req, input logic [3:0] pat, input int extra);
        int maxl = 0;
        int last = 0;
        int lr;
        for (int i = 0; i < 4; i++)
            if (exp_ticks(rail_dly_code[2*i +: 2]) > maxl) maxl = exp_ticks(rail_dly_code[2*i +: 2]);
        lr = exp_ticks(rst_dly_code);
        measure((maxl + lr) * TC + 40 + extra);
        for (int i = 0; i < 4; i++) begin
            int l = exp_ticks(rail_dly_code[2*i +: 2]);
            if (pat[i]) begin
                chk_win(req, $sformatf("good_n[%0d] fall cycle", i), fall_t[i],
                        (l - 1) * TC, l * TC + 2 + extra);
                if (fall_t[i] > last) last = fall_t[i];
            end else begin
                chk_eq("R9", $sformatf("good_n[%0d] stays inactive", i), fall_t[i], -1);
            end
        end
        if (pat == 4'hF)
            chk_win("R5", "sys_rst_n release after last good", rise_t - last,
                    (lr - 1) * TC, lr * TC + 3);
        else
            chk_eq("R9", "sys_rst_n held with a rail low", rise_t, -1);
    endtask

    task automatic start(input string req, input logic [3:0] pat,
                         input logic [7:0] codes, input logic [1:0] rc);
        rail_ok = 4'h0;
        idle(3);
        rail_dly_code = codes;
        rst_dly_code  = rc;
        rail_ok = pat;
        run_and_check(req, pat, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1..all: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1;
        rail_ok = 4'h0;
        mr_in = 1'b0;
        rail_dly_code = 8'h00;
        rst_dly_code = 2'b00;
        idle(5);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk_eq("R1", "good_n after reset", int'(good_n), 'hF);
        chk_eq("R1", "sys_rst_n after reset", int'(sys_rst_n), 0);
        idle(40);
        chk_eq("R1", "good_n with rails low", int'(good_n), 'hF);
        chk_eq("R1", "sys_rst_n with rails low", int'(sys_rst_n), 0);

        // R2 / R9: a different code on every channel
        start("R2", 4'hF, 8'b11_10_01_00, 2'b00);
        // R5: reset delay codes
        start("R5", 4'hF, 8'h00, 2'b01);
        start("R5", 4'hF, 8'h00, 2'b11);
        rst_dly_code = 2'b00;
        idle(4);

        // R3 / R4: drop one rail after the chain has settled
        rail_ok[2] = 1'b0;
        idle(2);
        chk_eq("R3", "good_n after rail 2 drop", int'(good_n), 'h4);
        idle(1);
        chk_eq("R4", "sys_rst_n after rail drop", int'(sys_rst_n), 0);
        rail_ok[2] = 1'b1;
        measure(100 * TC * 2 + 40);
        chk_win("R3", "rail 2 requalifies from zero", fall_t[2], 99 * TC, 100 * TC + 2);

        // R3: glitch partway through a count restarts it
        rail_ok[0] = 1'b0;
        idle(3);
        rail_ok[0] = 1'b1;
        idle(200);
        chk_eq("R3", "good_n[0] still counting", int'(good_n[0]), 1);
        rail_ok[0] = 1'b0;
        idle(1);
        rail_ok[0] = 1'b1;
        measure(100 * TC * 2 + 40);
        chk_win("R3", "good_n[0] after glitch restart", fall_t[0], 99 * TC, 100 * TC + 2);

        // R8: code change during a count is not used until the next start
        rail_ok[0] = 1'b0;
        rail_dly_code = 8'b00_00_00_01;
        idle(3);
        rail_ok[0] = 1'b1;
        idle(100);
        rail_dly_code = 8'h00;
        measure(600 * TC + 40);
        chk_win("R8", "good_n[0] keeps latched 500-tick code", fall_t[0],
                499 * TC - 100, 500 * TC + 2 - 100);
        chk_win("R8", "sys_rst_n after code-change run", rise_t - fall_t[0], 99 * TC, 100 * TC + 3);

        // R6: short manual-reset pulse ignored
        mr_in = 1'b1;
        idle(3);
        mr_in = 1'b0;
        idle(30);
        chk_eq("R6", "good_n after short MR pulse", int'(good_n), 0);
        chk_eq("R6", "sys_rst_n after short MR pulse", int'(sys_rst_n), 1);

        // R6 / R7: long manual reset forces, then resequences
        mr_in = 1'b1;
        idle(MRS + 6);
        chk_eq("R6", "good_n forced by MR", int'(good_n), 'hF);
        chk_eq("R6", "sys_rst_n forced by MR", int'(sys_rst_n), 0);
        idle(20);
        chk_eq("R6", "good_n still forced", int'(good_n), 'hF);
        rail_dly_code = 8'b01_00_01_00;
        mr_in = 1'b0;
        run_and_check("R7", 4'hF, MRS + 4);

        // R2 / R9: random rail patterns and short codes
        for (int it = 0; it < 8; it++) begin
            logic [3:0] pat;
            logic [7:0] codes;
            for (int i = 0; i < 4; i++) codes[2*i +: 2] = 2'($urandom % 2);
            pat = (it < 2) ? 4'hF : 4'($urandom % 16);
            start("R2", pat, codes, 2'($urandom % 2));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule